// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block holds 64 single-precision slots of 32 bits each. It serves them through several views: a raw single view and a raw double view, banked single and double views for the current bank and the opposite bank, a move view whose shape depends on a transfer-size mode, and a mixed view whose shape depends on a precision mode. A double is two neighbouring slots. The lower-numbered slot holds the upper half.

The bank, transfer-size and precision selections are bits of an internal 32-bit control word. That word can be loaded whole, or changed one bit at a time without touching the others. There is one combinational read port and one write port. The write port takes effect on the rising clock edge. Each port has its own view select.

The block does not convert between precisions. When the mixed view falls back to a single access, the block flags a conversion request on that port and leaves the conversion to the datapath around it.

Top module: `fp_bank_regfile`

## Requirements
- R1: After reset every slot reads zero and `ctl_q` is zero.
- R2: View code 0 is a raw single access to slot `idx`.
  - A single read returns the slot in bits 31:0, and bits 63:32 are zero.
  - A single write stores `wr_data[31:0]`.
- R3: The control word has three mode bits:
  - bit 21 is the bank;
  - bit 20 is the transfer size;
  - bit 19 is the precision.
  - `ctl_wr_en` loads all 32 bits.
  - `bit_wr_en` sets one bit to `bit_val`, chosen by `bit_sel`: 0 is bank, 1 is size, 2 is precision, and 3 changes nothing. It leaves all other bits unchanged.
  - When both loads happen in the same cycle, the bit update is applied on top of the full-word value.
- R4: View code 1 is a current-bank single at slot 16*bank + idx[3:0]. View code 2 is an other-bank single at slot 16*(1-bank) + idx[3:0].
- R5: Double views read {slot[b], slot[b+1]}, and a double write stores the upper 32 bits in b and the lower 32 bits in b+1. The base b depends on the view:
  - view code 3: b = idx;
  - view code 4: b = 16*bank + idx[3:0];
  - view code 5: b = 16*(1-bank) + idx[3:0].
- R6: A double access with an odd base raises `rd_err` or `wr_err`. Such a read returns zero, and such a write changes no slot.
- R7: View code 6 is the move view, and its shape depends on the size bit:
  - size bit 0: a current-bank single at idx[3:0];
  - size bit 1 and odd idx[3:0]: an other-bank double at idx[3:0] with bit 0 cleared;
  - size bit 1 and even idx[3:0]: a raw double at base idx[3:0].
- R8: View code 7 is the mixed view, and its shape depends on the precision bit:
  - precision bit 1: a current-bank double;
  - precision bit 0: a current-bank single, with `rd_cvt` (read port) or `wr_cvt` (write port, while `wr_en` is high) asserted.
- R9: A write lands on the rising clock edge, so a read of the same slot in that cycle returns the old value. A write decodes its slot with the control word held before that edge, even when the control word changes at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Load the whole control word |
| ctl_wr_data | input | 32 | Control word value |
| bit_wr_en | input | 1 | Update one mode bit |
| bit_sel | input | 2 | Mode bit select: 0 bank, 1 size, 2 precision |
| bit_val | input | 1 | New mode bit value |
| ctl_q | output | 32 | Current control word |
| wr_en | input | 1 | Write strobe |
| wr_view | input | 3 | Write view code |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data (singles use bits 31:0) |
| wr_err | output | 1 | Write rejected, odd double base |
| wr_cvt | output | 1 | Write needs precision conversion |
| rd_view | input | 3 | Read view code |
| rd_idx | input | 6 | Read index |
| rd_data | output | 64 | Read data |
| rd_err | output | 1 | Read invalid, odd double base |
| rd_cvt | output | 1 | Read needs precision conversion |

## Verification
Two events can fall in the same cycle: a data write, and a change to the control word that moves the bank the write decodes against. The bench provokes this by flipping the bank bit in the cycle that writes a current-bank single. In that same cycle it reads the target slot through the raw view. The outcome is judged in three ways:
- The read in the write cycle must show the old contents.
- After the edge, the slot of the old bank must hold the new data.
- The same slot in the new bank must be untouched.

// File: rtl/fpbr_pkg.sv
package fpbr_pkg;

  typedef enum logic [2:0] {
    VW_RAW_S = 3'd0,
    VW_CUR_S = 3'd1,
    VW_OTH_S = 3'd2,
    VW_RAW_D = 3'd3,
    VW_CUR_D = 3'd4,
    VW_OTH_D = 3'd5,
    VW_MOVE  = 3'd6,
    VW_MIXED = 3'd7
  } view_e;

  localparam int BANK_POS = 21;
  localparam int SIZE_POS = 20;
  localparam int PREC_POS = 19;

  localparam logic [1:0] SEL_BANK = 2'd0;
  localparam logic [1:0] SEL_SIZE = 2'd1;
  localparam logic [1:0] SEL_PREC = 2'd2;

endpackage

// File: rtl/fpbr_ctl.sv
module fpbr_ctl #(
  parameter int CW       = 32,
  parameter int BANK_POS = fpbr_pkg::BANK_POS,
  parameter int SIZE_POS = fpbr_pkg::SIZE_POS,
  parameter int PREC_POS = fpbr_pkg::PREC_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_we,
  input  logic [CW-1:0] full_data,
  input  logic          bit_we,
  input  logic [1:0]    bit_sel,
  input  logic          bit_val,
  output logic [CW-1:0] q
);
  import fpbr_pkg::*;

  logic [CW-1:0] bit_mask;
  logic [CW-1:0] base_val;
  logic [CW-1:0] nxt;

  // one-hot mask of the selected mode bit (zero for the unused code)
  function automatic logic [CW-1:0] sel_mask(input logic [1:0] s);
    logic [CW-1:0] m;
    m = '0;
    case (s)
      SEL_BANK: m[BANK_POS] = 1'b1;
      SEL_SIZE: m[SIZE_POS] = 1'b1;
      SEL_PREC: m[PREC_POS] = 1'b1;
      default:  m = '0;
    endcase
    return m;
  endfunction

  assign bit_mask = sel_mask(bit_sel);
  assign base_val = full_we ? full_data : q;

  always_comb begin
    nxt = base_val;
    if (bit_we)
      nxt = (base_val & ~bit_mask) | (bit_val ? bit_mask : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R3: a single-bit update leaves every other bit alone
  assert_bit_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !full_we) |=> (((q ^ $past(q)) & ~$past(bit_mask)) == '0));

  // R3: a full load with no bit update takes the word verbatim
  assert_full_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_we && !bit_we) |=> (q == $past(full_data)));

endmodule

// File: rtl/fpbr_map.sv
module fpbr_map #(
  parameter int IDX_W   = 6,
  parameter int BANK_SZ = 16
) (
  input  logic [2:0]       view,
  input  logic [IDX_W-1:0] idx,
  input  logic             bank,
  input  logic             size,
  input  logic             prec,
  output logic [IDX_W-1:0] base,
  output logic             dbl,
  output logic             err,
  output logic             cvt
);
  import fpbr_pkg::*;

  localparam int SUB_W = $clog2(BANK_SZ);

  logic [SUB_W-1:0] sub;
  logic [IDX_W-1:0] cur_b;
  logic [IDX_W-1:0] oth_b;
  logic [IDX_W-1:0] pair_b;
  logic [IDX_W-1:0] raw_sub;

  // slot of in-bank offset s within bank sel
  function automatic logic [IDX_W-1:0] place(input logic sel,
                                             input logic [SUB_W-1:0] s);
    return (sel ? IDX_W'(BANK_SZ) : IDX_W'(0)) + IDX_W'(s);
  endfunction

  assign sub     = idx[SUB_W-1:0];
  assign cur_b   = place(bank, sub);
  assign oth_b   = place(~bank, sub);
  assign pair_b  = place(~bank, {sub[SUB_W-1:1], 1'b0});
  assign raw_sub = IDX_W'(sub);

  always_comb begin
    base = '0;
    dbl  = 1'b0;
    cvt  = 1'b0;
    case (view_e'(view))
      VW_RAW_S: base = idx;
      VW_CUR_S: base = cur_b;
      VW_OTH_S: base = oth_b;
      VW_RAW_D: begin base = idx;   dbl = 1'b1; end
      VW_CUR_D: begin base = cur_b; dbl = 1'b1; end
      VW_OTH_D: begin base = oth_b; dbl = 1'b1; end
      VW_MOVE: begin
        if (!size)       base = cur_b;
        else if (sub[0]) begin base = pair_b;  dbl = 1'b1; end
        else             begin base = raw_sub; dbl = 1'b1; end
      end
      VW_MIXED: begin
        base = cur_b;
        dbl  = prec;
        cvt  = ~prec;
      end
      default: base = idx;
    endcase
  end

  assign err = dbl & base[0];

endmodule

// File: rtl/fpbr_store.sv
module fpbr_store #(
  parameter int SLOT_W = 32,
  parameter int NSLOT  = 64,
  parameter int IDX_W  = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              wdbl,
  input  logic [IDX_W-1:0]  wbase,
  input  logic [2*SLOT_W-1:0] wdata,
  input  logic              rdbl,
  input  logic [IDX_W-1:0]  rbase,
  output logic [2*SLOT_W-1:0] rdata
);
  logic [SLOT_W-1:0] slot_vec [NSLOT];
  logic [IDX_W-1:0]  wnext;
  logic [IDX_W-1:0]  rnext;

  assign wnext = wbase + IDX_W'(1);
  assign rnext = rbase + IDX_W'(1);

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [SLOT_W-1:0] q;
    logic hit_hi;
    logic hit_lo;
    assign hit_hi = we && (wbase == IDX_W'(k));
    assign hit_lo = we && wdbl && (wnext == IDX_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (hit_hi) q <= wdbl ? wdata[2*SLOT_W-1:SLOT_W] : wdata[SLOT_W-1:0];
      else if (hit_lo) q <= wdata[SLOT_W-1:0];
    end
    assign slot_vec[k] = q;
  end

  assign rdata = rdbl ? {slot_vec[rbase], slot_vec[rnext]}
                      : {{SLOT_W{1'b0}}, slot_vec[rbase]};

  // R5: a double write puts its upper half at the base slot
  assert_dbl_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdbl) |=> (slot_vec[$past(wbase)] == $past(wdata[2*SLOT_W-1:SLOT_W])));

  // R6: the write strobe never carries an odd double base
  assert_no_odd_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdbl) |-> !wbase[0]);

endmodule

// File: rtl/fp_bank_regfile.sv
module fp_bank_regfile #(
  parameter int SLOT_W  = 32,
  parameter int NSLOT   = 64,
  parameter int BANK_SZ = 16,
  parameter int CW      = 32,
  parameter int VIEW_W  = 3,
  parameter int IDX_W   = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr_en,
  input  logic [CW-1:0]       ctl_wr_data,
  input  logic                bit_wr_en,
  input  logic [1:0]          bit_sel,
  input  logic                bit_val,
  output logic [CW-1:0]       ctl_q,
  input  logic                wr_en,
  input  logic [VIEW_W-1:0]   wr_view,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [2*SLOT_W-1:0] wr_data,
  output logic                wr_err,
  output logic                wr_cvt,
  input  logic [VIEW_W-1:0]   rd_view,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [2*SLOT_W-1:0] rd_data,
  output logic                rd_err,
  output logic                rd_cvt
);
  import fpbr_pkg::*;

  localparam int DW = 2 * SLOT_W;

  logic             bank_b, size_b, prec_b;
  logic [IDX_W-1:0] w_base, r_base;
  logic             w_dbl, w_err_i, w_cvt_i;
  logic             r_dbl, r_err_i, r_cvt_i;
  logic             w_commit;
  logic [DW-1:0]    r_raw;

  fpbr_ctl #(.CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .full_we(ctl_wr_en), .full_data(ctl_wr_data),
    .bit_we(bit_wr_en), .bit_sel(bit_sel), .bit_val(bit_val),
    .q(ctl_q)
  );

  assign bank_b = ctl_q[BANK_POS];
  assign size_b = ctl_q[SIZE_POS];
  assign prec_b = ctl_q[PREC_POS];

  fpbr_map #(.IDX_W(IDX_W), .BANK_SZ(BANK_SZ)) u_wmap (
    .view(wr_view), .idx(wr_idx), .bank(bank_b), .size(size_b), .prec(prec_b),
    .base(w_base), .dbl(w_dbl), .err(w_err_i), .cvt(w_cvt_i)
  );

  fpbr_map #(.IDX_W(IDX_W), .BANK_SZ(BANK_SZ)) u_rmap (
    .view(rd_view), .idx(rd_idx), .bank(bank_b), .size(size_b), .prec(prec_b),
    .base(r_base), .dbl(r_dbl), .err(r_err_i), .cvt(r_cvt_i)
  );

  assign w_commit = wr_en & ~w_err_i;

  fpbr_store #(.SLOT_W(SLOT_W), .NSLOT(NSLOT), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(w_commit), .wdbl(w_dbl), .wbase(w_base), .wdata(wr_data),
    .rdbl(r_dbl), .rbase(r_base), .rdata(r_raw)
  );

  assign wr_err  = wr_en & w_err_i;
  assign wr_cvt  = wr_en & w_cvt_i;
  assign rd_err  = r_err_i;
  assign rd_cvt  = r_cvt_i;
  assign rd_data = r_err_i ? '0 : r_raw;

  // R6: an invalid read shows zero data
  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_data == '0));

  // R8: a conversion request always comes with a single-width result
  assert_cvt_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cvt |-> (rd_data[DW-1:SLOT_W] == '0));

  // R2: raw single reads carry nothing in the upper half
  assert_single_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_view == VIEW_W'(VW_RAW_S)) |-> (rd_data[DW-1:SLOT_W] == '0));

endmodule

// File: tb/fp_bank_regfile_bench.sv
module fp_bank_regfile_bench;
  import fpbr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [31:0] ctl_wr_data = '0;
  logic        bit_wr_en = 1'b0;
  logic [1:0]  bit_sel = '0;
  logic        bit_val = 1'b0;
  logic [31:0] ctl_q;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_view = '0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        wr_err, wr_cvt;
  logic [2:0]  rd_view = '0;
  logic [5:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic        rd_err, rd_cvt;

  int total = 0;
  int bad = 0;
  logic [31:0] m [64];
  logic [31:0] mctl = '0;

  always #2 clk = ~clk;

  fp_bank_regfile u_fp_bank_regfile (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .bit_wr_en(bit_wr_en), .bit_sel(bit_sel), .bit_val(bit_val),
    .ctl_q(ctl_q),
    .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_err(wr_err), .wr_cvt(wr_cvt),
    .rd_view(rd_view), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_err(rd_err), .rd_cvt(rd_cvt)
  );

  task automatic chk(input string req, input logic [65:0] act, input logic [65:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side mapping restated from the requirements
  function automatic void predict(input int v, input int i, output int b,
                                  output bit d, output bit e, output bit c);
    int bk, sz, pr, lo;
    bk = int'(mctl[21]); sz = int'(mctl[20]); pr = int'(mctl[19]);
    lo = i % 16;
    d = 0; c = 0; b = i;
    case (v)
      0: b = i;
      1: b = 16 * bk + lo;
      2: b = 16 * (1 - bk) + lo;
      3: begin b = i; d = 1; end
      4: begin b = 16 * bk + lo; d = 1; end
      5: begin b = 16 * (1 - bk) + lo; d = 1; end
      6: begin
        if (sz == 0) b = 16 * bk + lo;
        else if (lo % 2 == 1) begin b = 16 * (1 - bk) + lo - 1; d = 1; end
        else begin b = lo; d = 1; end
      end
      default: begin b = 16 * bk + lo; d = (pr == 1); c = (pr == 0); end
    endcase
    e = d && (b % 2 == 1);
  endfunction

  function automatic logic [65:0] expect_rd(input int v, input int i);
    int b; bit d, e, c;
    predict(v, i, b, d, e, c);
    if (e) return {1'b1, c, 64'h0};
    if (d) return {1'b0, c, m[b], m[b+1]};
    return {1'b0, c, 32'h0, m[b]};
  endfunction

  task automatic rd_chk(input string req, input int v, input int i);
    @(negedge clk);
    rd_view = 3'(v); rd_idx = 6'(i);
    #1;
    chk(req, {rd_err, rd_cvt, rd_data}, expect_rd(v, i));
  endtask

  task automatic wr_do(input string req, input int v, input int i, input logic [63:0] dat);
    int b; bit d, e, c;
    @(negedge clk);
    predict(v, i, b, d, e, c);
    wr_en = 1'b1; wr_view = 3'(v); wr_idx = 6'(i); wr_data = dat;
    #1;
    chk(req, {64'h0, wr_err, wr_cvt}, {64'h0, e, c});
    @(posedge clk);
    if (!e) begin
      if (d) begin m[b] = dat[63:32]; m[b+1] = dat[31:0]; end
      else m[b] = dat[31:0];
    end
    #1 wr_en = 1'b0;
  endtask

  task automatic ctl_full(input logic [31:0] v);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_data = v;
    @(posedge clk);
    mctl = v;
    #1 ctl_wr_en = 1'b0;
  endtask

  task automatic ctl_bit(input logic [1:0] s, input logic val);
    @(negedge clk);
    bit_wr_en = 1'b1; bit_sel = s; bit_val = val;
    @(posedge clk);
    if (s != 2'd3) mctl[21 - int'(s)] = val;
    #1 bit_wr_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ctl", {34'h0, ctl_q}, 66'h0);
    rd_chk("R1 slot0", 0, 0);
    rd_chk("R1 slot63", 0, 63);
    rd_chk("R1 dbl40", 3, 40);
  endtask

  task automatic t_raw;
    wr_do("R2 wr5", 0, 5, 64'hDEAD_0000_1111_2222);
    wr_do("R2 wr40", 0, 40, 64'h0000_0000_3333_4444);
    rd_chk("R2 rd5", 0, 5);
    rd_chk("R2 rd40", 0, 40);
  endtask

  task automatic t_ctl;
    ctl_full(32'hFFFF_FFFF);
    ctl_bit(2'd0, 1'b0);
    @(negedge clk); chk("R3 clear bank", {34'h0, ctl_q}, {34'h0, 32'hFFDF_FFFF});
    ctl_bit(2'd3, 1'b0);
    @(negedge clk); chk("R3 sel3 noop", {34'h0, ctl_q}, {34'h0, 32'hFFDF_FFFF});
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_data = 32'h0000_0001;
    bit_wr_en = 1'b1; bit_sel = 2'd2; bit_val = 1'b1;
    @(posedge clk); mctl = 32'h0008_0001;
    #1 begin ctl_wr_en = 1'b0; bit_wr_en = 1'b0; end
    @(negedge clk); chk("R3 both", {34'h0, ctl_q}, {34'h0, 32'h0008_0001});
    ctl_full(32'h0);
  endtask

  task automatic t_bank;
    wr_do("R4 cur b0", 1, 3, 64'h0000_0000_AAAA_0003);
    rd_chk("R4 raw3", 0, 3);
    ctl_bit(2'd0, 1'b1);
    rd_chk("R4 cur b1", 1, 3);
    rd_chk("R4 oth b1", 2, 3);
    wr_do("R4 cur b1 wr", 1, 3, 64'h0000_0000_BBBB_0013);
    rd_chk("R4 raw19", 0, 19);
    wr_do("R4 oth wr", 2, 9, 64'h0000_0000_CCCC_0009);
    rd_chk("R4 raw9", 0, 9);
  endtask

  task automatic t_dbl;
    wr_do("R5 raw dbl", 3, 10, 64'h1010_1010_1111_1111);
    rd_chk("R5 raw10", 0, 10);
    rd_chk("R5 raw11", 0, 11);
    wr_do("R5 cur dbl", 4, 2, 64'h1818_0000_1919_0000);
    rd_chk("R5 raw18", 0, 18);
    rd_chk("R5 raw19", 0, 19);
    wr_do("R5 oth dbl", 5, 4, 64'h0404_0404_0505_0505);
    rd_chk("R5 rd oth", 5, 4);
    rd_chk("R5 raw4", 0, 4);
  endtask

  task automatic t_err;
    wr_do("R6 odd cur", 4, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R6 slot19 kept", 0, 19);
    rd_chk("R6 slot20 kept", 0, 20);
    rd_chk("R6 raw odd rd", 3, 7);
    wr_do("R6 raw odd wr", 3, 41, 64'h1234_5678_9ABC_DEF0);
    rd_chk("R6 slot41 kept", 0, 41);
    rd_chk("R6 slot42 kept", 0, 42);
  endtask

  task automatic t_move;
    rd_chk("R7 size0", 6, 3);
    ctl_bit(2'd1, 1'b1);
    rd_chk("R7 odd oth", 6, 5);
    rd_chk("R7 even raw", 6, 10);
    wr_do("R7 odd wr", 6, 7, 64'h0606_0606_0707_0707);
    rd_chk("R7 raw6", 0, 6);
    rd_chk("R7 raw7", 0, 7);
    ctl_bit(2'd1, 1'b0);
  endtask

  task automatic t_mixed;
    rd_chk("R8 cvt rd", 7, 3);
    wr_do("R8 cvt wr", 7, 4, 64'h0000_0000_7777_0014);
    rd_chk("R8 raw20", 0, 20);
    ctl_bit(2'd2, 1'b1);
    rd_chk("R8 dbl rd", 7, 2);
    wr_do("R8 dbl wr", 7, 6, 64'h2222_0016_2323_0017);
    rd_chk("R8 raw23", 0, 23);
    ctl_bit(2'd2, 1'b0);
  endtask

  task automatic t_same;
    ctl_bit(2'd0, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_view = 3'd1; wr_idx = 6'd1; wr_data = 64'h0000_0000_5A5A_0001;
    bit_wr_en = 1'b1; bit_sel = 2'd0; bit_val = 1'b1;
    rd_view = 3'd0; rd_idx = 6'd1;
    #1;
    chk("R9 old value", {2'b00, rd_data}, {2'b00, 32'h0, m[1]});
    @(posedge clk);
    m[1] = 32'h5A5A_0001; mctl[21] = 1'b1;
    #1 begin wr_en = 1'b0; bit_wr_en = 1'b0; end
    rd_chk("R9 old bank got it", 0, 1);
    rd_chk("R9 new bank untouched", 0, 17);
    @(negedge clk); chk("R9 bank flipped", {34'h0, ctl_q}, {34'h0, mctl});
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_raw();
    t_ctl();
    t_bank();
    t_dbl();
    t_err();
    t_move();
    t_mixed();
    t_same();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule